// File: doc/BRIEF.md
# Fractional-Trim UART Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. Its bit timer is driven by a coarse integer divisor. A bit normally lasts sixteen sub-ticks, and each sub-tick is `divisor+1` clocks long. A trim word holds a two-bit code for every bit position of the frame. Each code can stretch its bit to seventeen sub-ticks or shrink it to fifteen. Spreading these one-sixteenth corrections over a frame brings the average bit rate close to the target rate, even when the integer divisor alone cannot reach it.

Software or a neighbouring block supplies the divisor, the trim word and the line format. The line format covers the data length, the parity mode and the stop count. Bytes enter through a valid/ready handshake into a one-entry holding register. The serializer takes a byte from that register whenever it is idle, or when it finishes the last stop bit of the current frame, so frames can run back to back. The divisor, trim word and format are captured when a frame is loaded and stay fixed for the whole frame.

Top module: `uart_trim_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_empty` is 1 and `tx_ready` is 1.
- R2: A frame is sent in this order:
  - a low start bit;
  - the data bits, LSB first, with `data_len` values 0..3 giving 5..8 data bits;
  - an optional parity bit;
  - the stop bits, high, with `stop_sel` 0 giving one stop bit and 1 giving two.
- R3: The `parity_mode` values behave as follows:
  - 0..3: no parity bit;
  - 4: odd parity, so the data bits plus the parity bit hold an odd number of ones;
  - 5: even parity;
  - 6: the parity bit is forced to 1;
  - 7: the parity bit is forced to 0.
- R4: A frame bit whose trim code is 0 or 2 lasts 16*(divisor+1) clocks.
- R5: Frame bit i (start bit = 0) takes its code from `trim[2i+1:2i]`. Code 1 makes that bit last 17*(divisor+1) clocks, and code 3 makes it last 15*(divisor+1) clocks.
- R6: Trim codes at bit indices at or beyond the frame length are ignored. The line returns high, and the block is idle, in the clock that follows the end of the last stop bit.
- R7: A byte is accepted in a clock where `tx_valid` and `tx_ready` are both 1. While the holding register is full, `tx_ready` is 0. A byte that waits in the holding register has its start bit begin in the clock right after the previous frame's last stop bit, with no idle gap.
- R8: `tx_empty` is 1 exactly when no frame is being sent and the holding register is empty. While a frame is in progress, `tx_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | DIV_W | Sub-tick length minus one, in clocks |
| trim | input | 24 | Two-bit trim code per frame bit |
| data_len | input | 2 | Data length: value + 5 bits |
| stop_sel | input | 1 | 0 = one stop bit, 1 = two stop bits |
| parity_mode | input | 3 | Parity selection (see R3) |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_line | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | No frame in progress and nothing held |

## Verification
A wrong sub-tick or prescale count shows up as a bit whose width is off by at least one clock. This appears on `tx_line` within the first bit of a frame, so the bench compares every clock of every frame bit against arithmetically computed widths. A wrong bit index or frame length shows up within one bit time at the frame end: the line carries a stray bit instead of going idle, or the line is cut short. Bad holding-register state shows up as a gap before, or a loss of, the second of two back-to-back frames, or as `tx_ready` or `tx_empty` disagreeing with the line within a clock.

// File: rtl/uart_trim_pkg.sv
package uart_trim_pkg;
   localparam int FRAME_MAX = 12;
   localparam int TRIM_W    = 2 * FRAME_MAX;
   localparam int IDX_W     = $clog2(FRAME_MAX);

   typedef enum logic [1:0] {
      TRIM_NOM   = 2'd0,
      TRIM_LONG  = 2'd1,
      TRIM_NOP   = 2'd2,
      TRIM_SHORT = 2'd3
   } trim_code_e;

   typedef enum logic [2:0] {
      PAR_ODD  = 3'd4,
      PAR_EVEN = 3'd5,
      PAR_ONE  = 3'd6,
      PAR_ZERO = 3'd7
   } parity_e;
endpackage

// File: rtl/uart_trim_frame.sv
module uart_trim_frame
   import uart_trim_pkg::*;
(
   input  logic [7:0]           data,
   input  logic [1:0]           data_len,
   input  logic                 stop_sel,
   input  logic [2:0]           parity_mode,
   output logic [FRAME_MAX-1:0] bits,
   output logic [IDX_W:0]       len
);
   logic [7:0] masked;
   logic       par_en;
   logic       par_bit;
   int         nd;

   assign masked = data & (8'hFF >> (2'd3 - data_len));
   assign par_en = parity_mode[2];

   always_comb begin
      case (parity_mode)
         PAR_ODD:  par_bit = ~^masked;
         PAR_EVEN: par_bit = ^masked;
         PAR_ONE:  par_bit = 1'b1;
         default:  par_bit = 1'b0;
      endcase
   end

   always_comb begin
      nd = 5 + int'(data_len);
      bits = '1;
      bits[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i < nd) bits[1+i] = data[i];
      end
      if (par_en) bits[1+nd] = par_bit;
      len = (IDX_W+1)'(2 + nd + int'(par_en) + int'(stop_sel));
   end
endmodule

// File: rtl/uart_trim_timer.sv
module uart_trim_timer
   import uart_trim_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int SUB_N   = 16,
   parameter bit TRIM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   input  logic [1:0]       code,
   output logic             bit_done
);
   localparam int SUB_W = $clog2(SUB_N + 2);

   logic [DIV_W-1:0] pre_cnt;
   logic [SUB_W-1:0] sub_cnt;
   logic [SUB_W-1:0] sub_last;

   initial begin
      assert (SUB_N >= 4) else $error("SUB_N too small");
      assert (DIV_W >= 1) else $error("DIV_W must be positive");
   end

   generate
      if (TRIM_EN) begin : g_trim
         always_comb begin
            case (trim_code_e'(code))
               TRIM_LONG:  sub_last = SUB_W'(SUB_N);
               TRIM_SHORT: sub_last = SUB_W'(SUB_N - 2);
               default:    sub_last = SUB_W'(SUB_N - 1);
            endcase
         end
      end else begin : g_fixed
         logic unused_code;
         assign unused_code = ^code;
         assign sub_last = SUB_W'(SUB_N - 1);
      end
   endgenerate

   assign bit_done = run && (pre_cnt == div) && (sub_cnt == sub_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         sub_cnt <= '0;
      end else if (!run || bit_done) begin
         pre_cnt <= '0;
         sub_cnt <= '0;
      end else if (pre_cnt == div) begin
         pre_cnt <= '0;
         sub_cnt <= sub_cnt + 1'b1;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   // R5
   sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_cnt <= SUB_W'(SUB_N));

   // R4
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> pre_cnt <= div);
endmodule

// File: rtl/uart_trim_tx.sv
module uart_trim_tx
   import uart_trim_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int SUB_N   = 16,
   parameter bit TRIM_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [TRIM_W-1:0] trim,
   input  logic [1:0]        data_len,
   input  logic              stop_sel,
   input  logic [2:0]        parity_mode,
   input  logic [7:0]        tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              tx_line,
   output logic              tx_empty
);
   logic                 hold_full;
   logic [7:0]           hold_data;
   logic                 busy;
   logic [FRAME_MAX-1:0] frame_q;
   logic [IDX_W:0]       len_q;
   logic [IDX_W-1:0]     bit_idx;
   logic [DIV_W-1:0]     div_q;
   logic [TRIM_W-1:0]    trim_q;
   logic [FRAME_MAX-1:0] frame_d;
   logic [IDX_W:0]       len_d;
   logic                 bit_done;
   logic                 last_bit;
   logic                 load;
   logic [1:0]           cur_code;

   uart_trim_frame u_frame (
      .data        (hold_data),
      .data_len    (data_len),
      .stop_sel    (stop_sel),
      .parity_mode (parity_mode),
      .bits        (frame_d),
      .len         (len_d)
   );

   assign cur_code = trim_q[{bit_idx, 1'b0} +: 2];

   uart_trim_timer #(
      .DIV_W   (DIV_W),
      .SUB_N   (SUB_N),
      .TRIM_EN (TRIM_EN)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (div_q),
      .code     (cur_code),
      .bit_done (bit_done)
   );

   assign last_bit = ({1'b0, bit_idx} == len_q - 1'b1);
   assign load     = hold_full && (!busy || (bit_done && last_bit));
   assign tx_ready = !hold_full;
   assign tx_line  = busy ? frame_q[bit_idx] : 1'b1;
   assign tx_empty = !busy && !hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (tx_valid && tx_ready) begin
         hold_full <= 1'b1;
         hold_data <= tx_data;
      end else if (load) begin
         hold_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         frame_q <= '1;
         len_q   <= '0;
         bit_idx <= '0;
         div_q   <= '0;
         trim_q  <= '0;
      end else if (load) begin
         busy    <= 1'b1;
         frame_q <= frame_d;
         len_q   <= len_d;
         bit_idx <= '0;
         div_q   <= divisor;
         trim_q  <= trim;
      end else if (bit_done) begin
         if (last_bit) busy <= 1'b0;
         else          bit_idx <= bit_idx + 1'b1;
      end
   end

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_idx == '0) |-> !tx_line);

   // R8
   empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> tx_line);

   // R7
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (!tx_ready && !tx_empty));

   // R6
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({1'b0, bit_idx} < len_q));
endmodule

// File: tb/tb_uart_trim_tx.sv
module tb_uart_trim_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  divisor = '0;
   logic [23:0] trim = '0;
   logic [1:0]  data_len = '0;
   logic        stop_sel = 1'b0;
   logic [2:0]  parity_mode = '0;
   logic [7:0]  tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic        tx_line;
   logic        tx_empty;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;

   always #2.5 clk = ~clk;

   uart_trim_tx dut (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .trim(trim),
      .data_len(data_len), .stop_sel(stop_sel), .parity_mode(parity_mode),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_line(tx_line), .tx_empty(tx_empty)
   );

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
         report();
         $finish;
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      while (!tx_ready) @(negedge clk);
      tx_data  = b;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic wait_start();
      int n = 0;
      while (tx_line !== 1'b0 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check("R2 start seen", tx_line, 1'b0);
      check("R8 busy not empty", tx_empty, 1'b0);
   endtask

   // Compares every clock of one frame; entry at its first start sample.
   task automatic check_frame(input logic [7:0] b, input bit next_follows);
      logic [11:0] eb;
      int nd, len, ones, w, sub, bad, code;
      logic p;
      string tag;
      nd = 5 + int'(data_len);
      eb = '1;
      eb[0] = 1'b0;
      ones = 0;
      for (int i = 0; i < nd; i++) begin
         eb[1+i] = b[i];
         ones += int'(b[i]);
      end
      len = 1 + nd;
      if (parity_mode[2]) begin
         case (parity_mode)
            3'd4: p = (ones % 2 == 0);
            3'd5: p = (ones % 2 == 1);
            3'd6: p = 1'b1;
            default: p = 1'b0;
         endcase
         eb[len] = p;
         len++;
      end
      len += 1 + int'(stop_sel);
      for (int i = 0; i < len; i++) begin
         code = int'(trim[2*i +: 2]);
         sub = (code == 1) ? 17 : (code == 3) ? 15 : 16;
         w = sub * (int'(divisor) + 1);
         if (code == 1 || code == 3) tag = "R5";
         else if (i == 0) tag = "R2";
         else if (parity_mode[2] && i == 1 + nd) tag = "R3";
         else tag = "R4";
         bad = -1;
         for (int k = 0; k < w; k++) begin
            if (tx_line !== eb[i] && bad < 0) bad = k;
            @(negedge clk);
         end
         vectors++;
         if (bad >= 0) begin
            errors++;
            $display("FAIL %s bit %0d: actual mismatch at clock %0d of %0d, expected %b",
                     tag, i, bad, w, eb[i]);
         end
      end
      if (next_follows) begin
         check("R7 back-to-back start", tx_line, 1'b0);
      end else begin
         check("R6 idle after last stop", tx_line, 1'b1);
         check("R8 empty after frame", tx_empty, 1'b1);
      end
   endtask

   logic [23:0] trims [5];

   initial begin
      logic [7:0] b;
      trims[0] = 24'h000000;
      trims[1] = 24'h555555;
      trims[2] = 24'hFFFFFF;
      trims[3] = 24'hAAAAAA;
      trims[4] = 24'hD9_3C_71;

      repeat (3) @(negedge clk);
      // R1
      check("R1 line", tx_line, 1'b1);
      check("R1 empty", tx_empty, 1'b1);
      check("R1 ready", tx_ready, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 line after release", tx_line, 1'b1);

      // full format sweep at divisor 0
      b = 8'hA5;
      for (int t = 0; t < 4; t++) begin
         for (int dl = 0; dl < 4; dl++) begin
            for (int st = 0; st < 2; st++) begin
               for (int pm = 2; pm < 8; pm++) begin
                  trim = trims[t + (pm == 2 ? 1 : 0)];
                  data_len = 2'(dl);
                  stop_sel = 1'(st);
                  parity_mode = 3'(pm);
                  divisor = '0;
                  b = {b[6:0], b[7] ^ b[5] ^ b[4] ^ b[3]};
                  send(b);
                  wait_start();
                  check_frame(b, 1'b0);
               end
            end
         end
      end

      // larger divisors, short frames with nonzero trailing trim codes (R6)
      for (int dv = 1; dv < 3; dv++) begin
         for (int t = 0; t < 5; t++) begin
            for (int dl = 0; dl < 4; dl += 3) begin
               divisor = 8'(dv);
               trim = trims[t];
               data_len = 2'(dl);
               stop_sel = 1'(dl == 3);
               parity_mode = (dl == 3) ? 3'd4 : 3'd0;
               b = 8'(37 * t + 11 * dv + dl);
               send(b);
               wait_start();
               check_frame(b, 1'b0);
            end
         end
      end

      // back-to-back frames through the holding register (R7)
      divisor = 8'd1;
      trim = 24'h3C_D1_57;
      data_len = 2'd3;
      stop_sel = 1'b0;
      parity_mode = 3'd5;
      fork
         begin
            send(8'h3C);
            send(8'hC3);
            check("R7 ready low while held", tx_ready, 1'b0);
         end
         begin
            wait_start();
            check_frame(8'h3C, 1'b1);
            check_frame(8'hC3, 1'b0);
         end
      join

      report();
      $finish;
   end
endmodule